// File: doc/BRIEF.md
# MDIO Management Controller with Register Front End

This block is a clause 22 MDIO master behind a small memory-mapped register port. Software loads a word that holds the PHY address and the register number. For a write it also loads the 16-bit data word. It then sets a read or a write request bit in the control register. The controller generates the management clock and shifts out the complete frame, MSB first. On a read it releases the data line for the turnaround and the data field, and samples the 16 returned bits on each rising MDC edge. A status busy bit tells software when the transfer has finished.

A request accepted while a transfer is running is held in the control register and starts once the line is free. The controller latches the address and write data when a frame starts. Register writes made during a frame therefore only affect the next one. The management clock runs only during a transfer and stays low otherwise. The data line is driven through an output value and a separate output enable, which an external pad cell combines.

Register map (byte offsets): control 0x00, address 0x04, write data 0x08, status 0x0C, read data 0x10.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status, control and read-data registers read 0, MDC is low and the MDIO output enable is low.
- R2: The address register takes the PHY address from bits 12:8 and the register number from bits 4:0. Both fields appear in the frame, in that order, right after the opcode.
- R3: A write frame is 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10 and then the 16 bits of the write-data register (bits 15:0), MSB first, with MDIO driven for all 64 bits.
- R4: A read frame is 32 ones, start 01, opcode 10, PHY address and register number, driven for 46 bits. MDIO is released (output enable low) for the last 18 bits: the turnaround and the data field.
- R5: On a read, the controller samples MDIO on the MDC rising edges of the 16 data bits, MSB first. The result appears in bits 15:0 of the read-data register at the end of the frame, and bits 31:16 read 0.
- R6: Status bit 0 reads 1 from the cycle after a request is written until the frame has completed, and reads 0 afterwards.
- R7: Control bit 3 requests a read and control bit 2 requests a write. Both bits clear themselves when the transfer starts, so the control register then reads 0.
- R8: When bits 3 and 2 are both set, the controller performs a write and clears both bits.
- R9: The MDC period is CLK_DIV system clocks (20, giving 2.5 MHz from 50 MHz). MDC is low when idle, and the MDIO output only changes while MDC is low.
- R10: A request written while a transfer is running stays visible in the control register. It starts after the current frame ends, and status stays 1 throughout.
- R11: Writes to the address or write-data register during a frame do not change that frame. They are used by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| mdio_i | input | 1 | MDIO value from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that MDIO input changes only while MDC is low. They also assume that register accesses are single-cycle strobes and that CLK_DIV is even and at least 4. The bench PHY model follows these rules: it updates mdio_i only on the falling MDC edge, and its bus tasks raise bus_sel for exactly one cycle between falling clock edges. Under these conditions, one rising MDC edge follows each output change half an MDC period later. A request that is written at the same time as a transfer starts is the only case in which the control bits are not seen to clear.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int FRAME_LEN  = 64;
    localparam int RELEASE_AT = 46;   // first bit index not driven on a read
    localparam int DATA_AT    = 48;   // first data bit index
    localparam int DATA_W     = 16;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_ADDR   = 'h04;
    localparam int OFS_WDATA  = 'h08;
    localparam int OFS_STAT   = 'h0C;
    localparam int OFS_RDATA  = 'h10;

    localparam int CTRL_RD_BIT = 3;
    localparam int CTRL_WR_BIT = 2;
    localparam int PHY_LSB     = 8;

    typedef struct packed {
        logic              rreq;
        logic              wreq;
        logic [4:0]        phy;
        logic [4:0]        regn;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    typedef struct packed {
        logic                 busy;
        logic                 wr;
        logic [5:0]           idx;
        logic [FRAME_LEN-1:0] sreg;
        logic [DATA_W-1:0]    rx;
    } frame_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int CLK_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(CLK_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;

    assign rise_o = run_i && (q.cnt == CNT_W'(HALF - 1));
    assign fall_o = run_i && (q.cnt == CNT_W'(CLK_DIV - 1));
    assign mdc_o  = q.mdc;

    always_comb begin
        d = q;
        if (!run_i) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else begin
            d.cnt = fall_o ? '0 : q.cnt + 1'b1;
            if (rise_o) d.mdc = 1'b1;
            if (fall_o) d.mdc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: clock is parked low whenever no transfer runs
    p_mdc_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);
    // R9: a high phase lasts more than one system cycle
    p_mdc_high_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |=> mdc_o);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_wr_i,
    input  logic [4:0]        phy_i,
    input  logic [4:0]        reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    frame_t q, d;
    logic [FRAME_LEN-1:0] frame_w;

    always_comb begin
        frame_w = {32'hFFFF_FFFF, 2'b01,
                   start_wr_i ? 2'b01 : 2'b10,
                   phy_i, reg_i,
                   start_wr_i ? 2'b10 : 2'b00,
                   start_wr_i ? wdata_i : {DATA_W{1'b0}}};
    end

    assign done_o    = q.busy && fall_i && (q.idx == 6'(FRAME_LEN - 1));
    assign rd_done_o = done_o && !q.wr;
    assign rd_data_o = q.rx;
    assign busy_o    = q.busy;
    assign mdio_o    = q.busy ? q.sreg[FRAME_LEN-1] : 1'b1;
    assign mdio_oe_o = q.busy && (q.wr || (q.idx < 6'(RELEASE_AT)));

    always_comb begin
        d = q;
        if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.wr   = start_wr_i;
            d.idx  = '0;
            d.sreg = frame_w;
            d.rx   = '0;
        end else if (q.busy) begin
            if (rise_i && !q.wr && (q.idx >= 6'(DATA_AT)))
                d.rx = {q.rx[DATA_W-2:0], mdio_i};
            if (fall_i) begin
                if (done_o) begin
                    d.busy = 1'b0;
                end else begin
                    d.idx  = q.idx + 1'b1;
                    d.sreg = {q.sreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a started frame reports busy
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R6: busy drops after the last falling edge
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R9: the line does not move at a rising MDC edge
    p_out_hold_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rise_i) |=> $stable(mdio_o) && $stable(mdio_oe_o));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              start_o,
    output logic              start_wr_o,
    output logic [4:0]        phy_o,
    output logic [4:0]        reg_o,
    output logic [DATA_W-1:0] wdata_o
);
    regs_t q, d;
    logic  ctrl_wr;

    assign start_o    = (q.rreq || q.wreq) && !busy_i;
    assign start_wr_o = q.wreq;
    assign phy_o      = q.phy;
    assign reg_o      = q.regn;
    assign wdata_o    = q.wdata;
    assign ctrl_wr    = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

    always_comb begin
        d = q;
        if (start_o) begin
            d.rreq = 1'b0;
            d.wreq = 1'b0;
        end
        if (bus_sel && bus_we) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                d.rreq = bus_wdata[CTRL_RD_BIT];
                d.wreq = bus_wdata[CTRL_WR_BIT];
            end
            if (bus_addr == ADDR_W'(OFS_ADDR)) begin
                d.phy  = bus_wdata[PHY_LSB+4:PHY_LSB];
                d.regn = bus_wdata[4:0];
            end
            if (bus_addr == ADDR_W'(OFS_WDATA))
                d.wdata = bus_wdata[DATA_W-1:0];
        end
        if (rd_done_i)
            d.rdata = rd_data_i;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                bus_rdata[CTRL_RD_BIT] = q.rreq;
                bus_rdata[CTRL_WR_BIT] = q.wreq;
            end
            if (bus_addr == ADDR_W'(OFS_ADDR)) begin
                bus_rdata[PHY_LSB+4:PHY_LSB] = q.phy;
                bus_rdata[4:0]               = q.regn;
            end
            if (bus_addr == ADDR_W'(OFS_WDATA))
                bus_rdata[DATA_W-1:0] = q.wdata;
            if (bus_addr == ADDR_W'(OFS_STAT))
                bus_rdata[0] = busy_i || q.rreq || q.wreq;
            if (bus_addr == ADDR_W'(OFS_RDATA))
                bus_rdata[DATA_W-1:0] = q.rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: request bits self-clear once the frame starts
    p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !ctrl_wr) |=> !(q.rreq || q.wreq));
    // R10: a pending request is kept while the line is busy
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.rreq || q.wreq) && busy_i && !ctrl_wr) |=> (q.rreq || q.wreq));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 20,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              busy_w, done_w, rd_done_w;
    logic              start_w, start_wr_w;
    logic              rise_w, fall_w;
    logic [4:0]        phy_w, reg_w;
    logic [DATA_W-1:0] wdata_w, rd_data_w;

    mdio_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_i(busy_w), .rd_done_i(rd_done_w), .rd_data_i(rd_data_w),
        .start_o(start_w), .start_wr_o(start_wr_w),
        .phy_o(phy_w), .reg_o(reg_w), .wdata_o(wdata_w)
    );

    mdio_clkdiv #(.CLK_DIV(CLK_DIV)) div_i (
        .clk(clk), .rst_n(rst_n), .run_i(busy_w),
        .mdc_o(mdc), .rise_o(rise_w), .fall_o(fall_w)
    );

    mdio_frame frame_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_w), .start_wr_i(start_wr_w),
        .phy_i(phy_w), .reg_i(reg_w), .wdata_i(wdata_w),
        .rise_i(rise_w), .fall_i(fall_w), .mdio_i(mdio_i),
        .busy_o(busy_w), .done_o(done_w), .rd_done_o(rd_done_w),
        .rd_data_o(rd_data_w), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
    );

    // R1: no clock and no drive straight out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> !mdc && !mdio_oe);
    // R6: a finished frame never coincides with MDC high
    p_done_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    localparam int DIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [127:0] expq[$];
    logic [15:0]  phy_resp = '0;
    int rcount = 0;

    mdio_mgmt_ctrl #(.CLK_DIV(DIV), .ADDR_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver: push the expected frame, pattern {value, drive mask}
    task automatic expect_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                                input logic [15:0] data);
        logic [63:0] v, m;
        v = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
             wr ? 2'b10 : 2'b00, wr ? data : 16'h0};
        m = wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
        expq.push_back({v, m});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_read(5'h0C, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    // monitor: collect 64 MDC rising-edge samples per frame and compare
    initial begin
        logic [63:0] ov, om, ev, em;
        logic [127:0] e;
        forever begin
            for (int b = 0; b < 64; b++) begin
                @(posedge mdc); #1;
                ov = {ov[62:0], mdio_o};
                om = {om[62:0], mdio_oe};
            end
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R3/R4 frame: actual %h unexpected, expected none", ov);
            end else begin
                e = expq.pop_front();
                ev = e[127:64]; em = e[63:0];
                if (om !== em || ((ov ^ ev) & em) != 64'h0) begin
                    errors++;
                    $display("FAIL R2/R3/R4 frame: actual %h/%h expected %h/%h", ov, om, ev, em);
                end
            end
        end
    end

    // PHY model: present read data on the falling MDC edge before each sample
    always @(posedge mdc) rcount <= (rcount == 63) ? 0 : rcount + 1;
    always @(negedge mdc) begin
        #1;
        if (rcount >= 48) mdio_i = phy_resp[63 - rcount];
        else              mdio_i = 1'b1;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(5'h0C, r); check("R1 status", r, 0);
        bus_read(5'h00, r); check("R1 control", r, 0);
        bus_read(5'h10, r); check("R1 rdata", r, 0);
        check("R1 mdc", mdc, 0);
        check("R1 oe", mdio_oe, 0);

        // R3 write with R2 address placement
        bus_write(5'h04, 32'h0000_111A);
        bus_write(5'h08, 32'h0000_A5C3);
        expect_frame(1'b1, 5'h11, 5'h1A, 16'hA5C3);
        bus_write(5'h00, 32'h4);
        bus_read(5'h00, r); check("R7 write req self-clear", r, 0);
        bus_read(5'h0C, r); check("R6 busy during write", r, 1);
        // R9 MDC period
        @(posedge mdc); #1 t0 = cyc;
        @(posedge mdc); #1 t1 = cyc;
        check("R9 mdc period", t1 - t0, DIV);
        wait_idle();
        bus_read(5'h0C, r); check("R6 idle after write", r, 0);
        check("R9 mdc low idle", mdc, 0);

        // R4/R5 reads with two data patterns
        phy_resp = 16'h1234;
        bus_write(5'h04, 32'h0000_0302);
        expect_frame(1'b0, 5'h03, 5'h02, 16'h0);
        bus_write(5'h00, 32'h8);
        bus_read(5'h00, r); check("R7 read req self-clear", r, 0);
        wait_idle();
        bus_read(5'h10, r); check("R5 read data 1234", r, 32'h0000_1234);

        phy_resp = 16'h8001;
        bus_write(5'h04, 32'h0000_1F1F);
        expect_frame(1'b0, 5'h1F, 5'h1F, 16'h0);
        bus_write(5'h00, 32'h8);
        wait_idle();
        bus_read(5'h10, r); check("R5 read data 8001", r, 32'h0000_8001);

        // R8 both requests: write wins
        bus_write(5'h04, 32'h0000_0A05);
        bus_write(5'h08, 32'h0000_0FF0);
        expect_frame(1'b1, 5'h0A, 5'h05, 16'h0FF0);
        bus_write(5'h00, 32'hC);
        bus_read(5'h00, r); check("R8 both bits cleared", r, 0);
        wait_idle();
        bus_read(5'h10, r); check("R8 read data untouched", r, 32'h0000_8001);

        // R10/R11 queued request and register changes mid-frame
        phy_resp = 16'h5AA5;
        bus_write(5'h04, 32'h0000_0101);
        bus_write(5'h08, 32'h0000_BEEF);
        expect_frame(1'b1, 5'h01, 5'h01, 16'hBEEF);
        expect_frame(1'b0, 5'h16, 5'h0C, 16'h0);
        bus_write(5'h00, 32'h4);
        repeat (50) @(negedge clk);
        bus_write(5'h04, 32'h0000_160C);
        bus_write(5'h08, 32'h0000_1111);
        bus_write(5'h00, 32'h8);
        bus_read(5'h00, r); check("R10 pending read held", r, 32'h8);
        bus_read(5'h0C, r); check("R10 status while pending", r, 1);
        wait_idle();
        bus_read(5'h10, r); check("R11 second frame data", r, 32'h0000_5AA5);

        repeat (10) @(negedge clk);
        check("R3/R4 all frames seen", expq.size(), 0);
        finish_run();
    end
endmodule